// File: doc/BRIEF.md
# Multi-Master Bus Arbiter

This block hands a shared asynchronous backplane bus to one of up to 20 bidding devices. Each bidder owns one open-collector request line. Because no separate grant wire exists, the arbiter grants a bidder by driving that same request line active alongside it. Every wired line is modelled as an active-high signal that is the OR of all drivers. The arbiter's output `gnt_o` is its own contribution to the request lines, bit n for device n.

A grant is issued only when no grant is already outstanding and the bidder's request is seen active. The busy, bus-acquired, vector, deallocate, cycle-abort and bus-reset lines must also all be quiescent. When several devices bid, a fixed priority picks one: by default the lowest index wins, and a parameter reverses this. While a master holds the bus, the arbiter asks it to release the bus whenever another bidder waits, unless the master signals a hold or retain sequence. A cycle that keeps the busy line active for too long is judged failed. The arbiter then drives the abort line for a fixed number of clocks and withdraws the grant. An interrupt flag raised by the granted master is latched together with that master's index until on-chip logic acknowledges it.

All bus inputs pass through a two-stage synchroniser before any decision uses them.

Top module: `mbus_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set; bit n set means the arbiter co-drives the request line of device n.
- R2: A new grant is given only when no grant is outstanding and only to a device whose synchronised request is active; an outstanding grant is never moved to another device without first returning to zero.
- R3: No grant is issued while any of busy, bus-acquired, vector, deallocate, abort (driven by others or by the arbiter itself) or bus-reset is active.
- R4: With PRIO = PRIO_LOW_WINS (default) the lowest-index bidder is granted; with PRIO_HIGH_WINS the highest-index bidder is granted.
- R5: `rel_o` is 1 while a grant is outstanding, some other request line is active, and neither hold nor retain is active; otherwise it is 0.
- R6: If busy stays active for TIMEOUT consecutive synchronised cycles while a grant is outstanding, `abort_o` rises; any cycle with busy quiescent restarts the count.
- R7: `abort_o` stays high for exactly ABORT_LEN clocks, the grant is held during that time, and the grant is zero in the cycle `abort_o` falls.
- R8: A request driven before clock edge k produces its grant after edge k+2, and not earlier (two synchroniser stages plus the grant register).
- R9: When the granted device drops its request, the grant is withdrawn; the next grant may follow one clock later.
- R10: A rising interrupt flag while a grant is outstanding sets `irq_pend_o` and loads `irq_src_o` with the binary index of the granted device; a flag with no grant is ignored; while pending, later flags do not change the index; `irq_ack_i` clears the pending flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NDEV | Request lines as driven by the bidders, bit n = device n |
| busy_i | input | 1 | Bus busy line |
| acq_i | input | 1 | Bus acquired line |
| vec_i | input | 1 | Vector cycle line |
| dealloc_i | input | 1 | Bus deallocate line |
| abort_i | input | 1 | Cycle-abort line as driven by other devices |
| bus_rst_i | input | 1 | Bus reset line |
| hold_i | input | 1 | Master signals a hold sequence |
| retain_i | input | 1 | Master signals a retain (indivisible) sequence |
| irq_i | input | 1 | Interrupt flag from the master |
| irq_ack_i | input | 1 | Synchronous acknowledge clearing the latched interrupt |
| gnt_o | output | NDEV | Arbiter drive onto the request lines (the grant) |
| rel_o | output | 1 | Request to the current master to release the bus |
| abort_o | output | 1 | Arbiter drive onto the cycle-abort line |
| irq_pend_o | output | 1 | An interrupt has been captured |
| irq_src_o | output | IDW | Index of the device that raised the captured interrupt |

## Verification
Every cycle, the assertions check that the grant is one-hot or zero and is never moved directly between devices. They also check that a fresh grant follows an active request with every blocking line quiet, that no release request appears during hold or retain, that abort coincides with a held grant and ends with the grant gone, and that a pending interrupt index stays put. The bench scenarios show what a single-cycle property cannot. These are the priority order under both variants, the exact two-edge input latency, the timeout firing after exactly TIMEOUT busy cycles and being reset by a quiet cycle, the abort lasting ABORT_LEN clocks, and interrupts being ignored when no grant is outstanding.

// File: rtl/mbus_arb_pkg.sv
package mbus_arb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GRANT = 2'd1,
      ST_ABORT = 2'd2
   } arb_st_e;

   typedef enum logic {
      PRIO_LOW_WINS  = 1'b0,
      PRIO_HIGH_WINS = 1'b1
   } prio_e;

   localparam int unsigned MAX_DEVICES = 20;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mbus_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("mbus_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/mbus_prio_pick.sv
module mbus_prio_pick
   import mbus_arb_pkg::*;
#(
   parameter int unsigned N    = 4,
   parameter int unsigned IDW  = 2,
   parameter prio_e       PRIO = PRIO_LOW_WINS
) (
   input  logic [N-1:0]   req,
   output logic [N-1:0]   oh,
   output logic [IDW-1:0] idx,
   output logic           valid
);

   if ((1 << IDW) < N) begin : g_bad_idw
      $error("mbus_prio_pick: IDW too narrow for N");
   end

   if (PRIO == PRIO_LOW_WINS) begin : g_low
      always_comb begin
         logic hit;
         hit = 1'b0;
         oh  = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i] && !hit) begin
               oh[i] = 1'b1;
               hit   = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic hit;
         hit = 1'b0;
         oh  = '0;
         for (int i = N-1; i >= 0; i--) begin
            if (req[i] && !hit) begin
               oh[i] = 1'b1;
               hit   = 1'b1;
            end
         end
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (oh[i]) idx = idx | IDW'(i);
      end
   end

   assign valid = |req;

endmodule

// File: rtl/mbus_cycle_timer.sv
module mbus_cycle_timer #(
   parameter int unsigned LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic expire
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("mbus_cycle_timer: LIMIT must be at least 1");
   end

   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign expire = en && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!en)     cnt <= '0;
      else if (!expire) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/mbus_irq_latch.sv
module mbus_irq_latch #(
   parameter int unsigned IDW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           irq_s,
   input  logic           granted,
   input  logic [IDW-1:0] owner,
   input  logic           ack,
   output logic           pend,
   output logic [IDW-1:0] src
);

   logic irq_d;
   logic rise;

   assign rise = irq_s && !irq_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_d <= 1'b0;
         pend  <= 1'b0;
         src   <= '0;
      end else begin
         irq_d <= irq_s;
         if (ack) begin
            pend <= 1'b0;
         end else if (!pend && rise && granted) begin
            pend <= 1'b1;
            src  <= owner;
         end
      end
   end

endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
   import mbus_arb_pkg::*;
#(
   parameter int unsigned NDEV        = 20,
   parameter int unsigned TIMEOUT     = 256,
   parameter int unsigned ABORT_LEN   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter prio_e       PRIO        = PRIO_LOW_WINS,
   localparam int unsigned IDW        = (NDEV > 1) ? $clog2(NDEV) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NDEV-1:0] req_i,
   input  logic            busy_i,
   input  logic            acq_i,
   input  logic            vec_i,
   input  logic            dealloc_i,
   input  logic            abort_i,
   input  logic            bus_rst_i,
   input  logic            hold_i,
   input  logic            retain_i,
   input  logic            irq_i,
   input  logic            irq_ack_i,
   output logic [NDEV-1:0] gnt_o,
   output logic            rel_o,
   output logic            abort_o,
   output logic            irq_pend_o,
   output logic [IDW-1:0]  irq_src_o
);

   if (NDEV < 1 || NDEV > MAX_DEVICES) begin : g_bad_ndev
      $error("mbus_arbiter: NDEV out of range 1..20");
   end
   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("mbus_arbiter: TIMEOUT must be at least 2");
   end
   if (ABORT_LEN < 1) begin : g_bad_abort
      $error("mbus_arbiter: ABORT_LEN must be at least 1");
   end

   localparam int unsigned NCTL = 9;
   localparam int unsigned SW   = NDEV + NCTL;

   // synchronised copies of every bus input
   logic [SW-1:0]   sync_d;
   logic [SW-1:0]   sync_q;
   logic [NDEV-1:0] req_s;
   logic            busy_s, acq_s, vec_s, dea_s, abt_s, brst_s;
   logic            hold_s, ret_s, irq_s;

   assign sync_d = {irq_i, retain_i, hold_i, bus_rst_i, abort_i,
                    dealloc_i, vec_i, acq_i, busy_i, req_i};

   mbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_d),
      .q     (sync_q)
   );

   assign req_s  = sync_q[NDEV-1:0];
   assign busy_s = sync_q[NDEV+0];
   assign acq_s  = sync_q[NDEV+1];
   assign vec_s  = sync_q[NDEV+2];
   assign dea_s  = sync_q[NDEV+3];
   assign abt_s  = sync_q[NDEV+4];
   assign brst_s = sync_q[NDEV+5];
   assign hold_s = sync_q[NDEV+6];
   assign ret_s  = sync_q[NDEV+7];
   assign irq_s  = sync_q[NDEV+8];

   // priority choice among bidders
   logic [NDEV-1:0] pick_oh;
   logic [IDW-1:0]  pick_idx;
   logic            pick_valid;

   mbus_prio_pick #(.N(NDEV), .IDW(IDW), .PRIO(PRIO)) u_pick (
      .req   (req_s),
      .oh    (pick_oh),
      .idx   (pick_idx),
      .valid (pick_valid)
   );

   // grant state
   arb_st_e         state;
   logic [NDEV-1:0] gnt_q;
   logic [IDW-1:0]  idx_q;
   logic            blocked;
   logic            owner_req;
   logic            to_expire;
   logic            ab_expire;

   assign abort_o   = (state == ST_ABORT);
   assign blocked   = busy_s | acq_s | vec_s | dea_s | abt_s | abort_o | brst_s;
   assign owner_req = |(req_s & gnt_q);

   mbus_cycle_timer #(.LIMIT(TIMEOUT)) u_cycle_to (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     ((state == ST_GRANT) && busy_s),
      .expire (to_expire)
   );

   mbus_cycle_timer #(.LIMIT(ABORT_LEN)) u_abort_len (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (state == ST_ABORT),
      .expire (ab_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         gnt_q <= '0;
         idx_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!blocked && pick_valid) begin
                  state <= ST_GRANT;
                  gnt_q <= pick_oh;
                  idx_q <= pick_idx;
               end
            end
            ST_GRANT: begin
               if (!owner_req) begin
                  state <= ST_IDLE;
                  gnt_q <= '0;
               end else if (to_expire) begin
                  state <= ST_ABORT;
               end
            end
            ST_ABORT: begin
               if (ab_expire) begin
                  state <= ST_IDLE;
                  gnt_q <= '0;
               end
            end
            default: begin
               state <= ST_IDLE;
               gnt_q <= '0;
            end
         endcase
      end
   end

   assign gnt_o = gnt_q;
   assign rel_o = (state == ST_GRANT) && (|(req_s & ~gnt_q)) && !hold_s && !ret_s;

   mbus_irq_latch #(.IDW(IDW)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_s   (irq_s),
      .granted (state != ST_IDLE),
      .owner   (idx_q),
      .ack     (irq_ack_i),
      .pend    (irq_pend_o),
      .src     (irq_src_o)
   );

endmodule

// File: rtl/mbus_arbiter_chk.sv
module mbus_arbiter_chk #(
   parameter int unsigned NDEV = 4,
   parameter int unsigned IDW  = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NDEV-1:0] gnt_o,
   input logic [NDEV-1:0] req_s,
   input logic            busy_s,
   input logic            acq_s,
   input logic            vec_s,
   input logic            dea_s,
   input logic            abt_s,
   input logic            brst_s,
   input logic            hold_s,
   input logic            ret_s,
   input logic            rel_o,
   input logic            abort_o,
   input logic            irq_pend_o,
   input logic [IDW-1:0]  irq_src_o,
   input logic            irq_ack_i
);

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R1

   AST_GNT_TO_BIDDER: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && $past(gnt_o) == '0) |-> (($past(req_s) & gnt_o) != '0)); // R2

   AST_GNT_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0) |=> (gnt_o == '0 || $stable(gnt_o))); // R2

   AST_GNT_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o != '0 && $past(gnt_o) == '0) |->
         $past(!busy_s && !acq_s && !vec_s && !dea_s && !abt_s && !brst_s && !abort_o)); // R3

   AST_REL_RESPECTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s || ret_s) |-> !rel_o); // R5

   AST_ABORT_KEEPS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (gnt_o != '0)); // R7

   AST_ABORT_DROPS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(abort_o) |-> (gnt_o == '0)); // R7

   AST_IRQ_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_o && !irq_ack_i) |=> (irq_pend_o && $stable(irq_src_o))); // R10

endmodule

bind mbus_arbiter mbus_arbiter_chk #(.NDEV(NDEV), .IDW(IDW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gnt_o      (gnt_o),
   .req_s      (req_s),
   .busy_s     (busy_s),
   .acq_s      (acq_s),
   .vec_s      (vec_s),
   .dea_s      (dea_s),
   .abt_s      (abt_s),
   .brst_s     (brst_s),
   .hold_s     (hold_s),
   .ret_s      (ret_s),
   .rel_o      (rel_o),
   .abort_o    (abort_o),
   .irq_pend_o (irq_pend_o),
   .irq_src_o  (irq_src_o),
   .irq_ack_i  (irq_ack_i)
);

// File: tb/mbus_arbiter_bench.sv
`timescale 1ns/1ps
module mbus_arbiter_bench;
   import mbus_arb_pkg::*;

   localparam int unsigned NDEV = 4;
   localparam int unsigned TO   = 16;
   localparam int unsigned AL   = 4;
   localparam int unsigned IDW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NDEV-1:0] req = '0;
   logic busy = 0, acq = 0, vec = 0, dea = 0, abt = 0, brst = 0;
   logic hold = 0, ret = 0, irq = 0, ack = 0;

   logic [NDEV-1:0] gnt, gnt_hi;
   logic rel, rel_hi, abort, abort_hi, pend, pend_hi;
   logic [IDW-1:0] src, src_hi;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   mbus_arbiter #(.NDEV(NDEV), .TIMEOUT(TO), .ABORT_LEN(AL), .PRIO(PRIO_LOW_WINS)) u_mbus_arbiter (
      .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .acq_i(acq), .vec_i(vec),
      .dealloc_i(dea), .abort_i(abt), .bus_rst_i(brst), .hold_i(hold), .retain_i(ret),
      .irq_i(irq), .irq_ack_i(ack), .gnt_o(gnt), .rel_o(rel), .abort_o(abort),
      .irq_pend_o(pend), .irq_src_o(src));

   mbus_arbiter #(.NDEV(NDEV), .TIMEOUT(TO), .ABORT_LEN(AL), .PRIO(PRIO_HIGH_WINS)) u_mbus_arbiter_hi (
      .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .acq_i(acq), .vec_i(vec),
      .dealloc_i(dea), .abort_i(abt), .bus_rst_i(brst), .hold_i(hold), .retain_i(ret),
      .irq_i(irq), .irq_ack_i(ack), .gnt_o(gnt_hi), .rel_o(rel_hi), .abort_o(abort_hi),
      .irq_pend_o(pend_hi), .irq_src_o(src_hi));

   // vector: {req[3:0], busy, acq, vec, dealloc, abort, busrst, hold, retain, exp_gnt[3:0], exp_rel}
   localparam int NV = 13;
   localparam logic [16:0] VEC [NV] = '{
      {4'b0110, 8'b0000_0000, 4'b0010, 1'b1},  // R4 lowest wins, R5 other bidder waits
      {4'b0110, 8'b0000_0010, 4'b0010, 1'b0},  // R5 hold suppresses release
      {4'b0110, 8'b0000_0001, 4'b0010, 1'b0},  // R5 retain suppresses release
      {4'b0111, 8'b0000_0000, 4'b0010, 1'b1},  // R2 no preemption by lower index
      {4'b0101, 8'b0000_0000, 4'b0001, 1'b1},  // R9 owner drops, R4 next lowest
      {4'b0100, 8'b1000_0000, 4'b0000, 1'b0},  // R3 busy blocks
      {4'b0100, 8'b0100_0000, 4'b0000, 1'b0},  // R3 acquired blocks
      {4'b0100, 8'b0010_0000, 4'b0000, 1'b0},  // R3 vector blocks
      {4'b0100, 8'b0001_0000, 4'b0000, 1'b0},  // R3 deallocate blocks
      {4'b0100, 8'b0000_1000, 4'b0000, 1'b0},  // R3 abort line blocks
      {4'b0100, 8'b0000_0100, 4'b0000, 1'b0},  // R3 bus reset blocks
      {4'b0100, 8'b0000_0000, 4'b0100, 1'b0},  // R1 single grant once quiet
      {4'b0000, 8'b0000_0000, 4'b0000, 1'b0}   // R9 release
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      bit seen;
      int n;
      step(3);
      check("R1 reset gnt", 32'(gnt), 0);
      check("R5 reset rel", 32'(rel), 0);
      check("R7 reset abort", 32'(abort), 0);
      check("R10 reset pend", 32'(pend), 0);
      rst_n = 1'b1;
      step(2);

      // R8 latency: grant after the third edge
      req = 4'b0001;
      step(2);
      check("R8 no grant after two edges", 32'(gnt), 0);
      step(1);
      check("R8 grant after third edge", 32'(gnt), 32'h1);
      req = 4'b0000;
      step(6);
      check("R9 grant withdrawn", 32'(gnt), 0);

      for (int v = 0; v < NV; v++) begin
         {req, busy, acq, vec, dea, abt, brst, hold, ret} = VEC[v][16:5];
         step(6);
         check($sformatf("table vector %0d gnt", v), 32'(gnt), 32'(VEC[v][4:1]));
         check($sformatf("table vector %0d rel", v), 32'(rel), 32'(VEC[v][0]));
         if (v == 0) check("R4 high-wins variant", 32'(gnt_hi), 32'h4);
      end
      {req, busy, acq, vec, dea, abt, brst, hold, ret} = '0;

      // R6 / R7 timeout and abort
      req = 4'b0001;
      step(6);
      check("R6 setup grant", 32'(gnt), 32'h1);
      busy = 1'b1;
      step(TO + 1);
      check("R6 no abort before limit", 32'(abort), 0);
      step(1);
      check("R6 abort at limit", 32'(abort), 1);
      n = 1;
      for (int i = 0; i < 20 && abort; i++) begin
         check("R7 grant held during abort", 32'(gnt), 32'h1);
         step(1);
         if (abort) n++;
      end
      check("R7 abort length", 32'(n), 32'(AL));
      check("R7 grant dropped after abort", 32'(gnt), 0);
      step(4);
      check("R3 busy still blocks regrant", 32'(gnt), 0);
      busy = 1'b0;
      step(6);
      check("R3 regrant after quiet", 32'(gnt), 32'h1);

      // R6 timer restarts on a quiet cycle
      seen = 0;
      busy = 1'b1;
      for (int i = 0; i < TO - 2; i++) begin step(1); if (abort) seen = 1; end
      busy = 1'b0;
      for (int i = 0; i < 3; i++) begin step(1); if (abort) seen = 1; end
      busy = 1'b1;
      for (int i = 0; i < TO - 2; i++) begin step(1); if (abort) seen = 1; end
      busy = 1'b0;
      for (int i = 0; i < 4; i++) begin step(1); if (abort) seen = 1; end
      check("R6 quiet cycle restarts count", 32'(seen), 0);

      // R10 interrupt capture
      irq = 1'b1;
      step(5);
      check("R10 pend set", 32'(pend), 1);
      check("R10 src is owner 0", 32'(src), 0);
      irq = 1'b0;
      req = 4'b0010;
      step(6);
      check("R10 setup grant dev1", 32'(gnt), 32'h2);
      irq = 1'b1;
      step(5);
      check("R10 first source kept", 32'(src), 0);
      irq = 1'b0;
      ack = 1'b1;
      step(1);
      ack = 1'b0;
      check("R10 ack clears", 32'(pend), 0);
      step(3);
      irq = 1'b1;
      step(5);
      check("R10 src is owner 1", 32'(src), 1);
      check("R10 pend again", 32'(pend), 1);
      irq = 1'b0;
      ack = 1'b1;
      step(1);
      ack = 1'b0;
      req = 4'b0000;
      step(6);
      irq = 1'b1;
      step(5);
      check("R10 ignored without grant", 32'(pend), 0);
      irq = 1'b0;
      step(3);

      finish_run();
   end

endmodule